// File: doc/BRIEF.md
# HDLC Data-Link Frame Receiver

This block takes a serial bit-oriented data-link stream, one bit for each cycle in which the bit strobe is high. It locates the 01111110 delimiter, discards the zeros that a transmitter inserts after five ones, and packs the remaining frame bits into bytes, least significant bit first. The bytes go into a four-entry buffer that a host drains one byte per read strobe. The buffer also receives the two check-sequence bytes that close the frame.

When a frame closes, either with a delimiter or with an abort run of seven ones, the receiver updates a compact status word. That word records that a frame ended and whether an abort ended it. It also records whether the bit count after zero removal was not a whole number of bytes, whether a buffered byte was lost to overwrite, and whether the CRC-16 check failed while checking was enabled. The word holds its value until the next frame end that qualifies. Address decoding and any host bus protocol belong to the surrounding logic.

Top module: `hdlc_dl_rx`

## Requirements
- R1: After reset, `status` is all zero and `rd_valid` is low.
- R2: A flag is the pattern 01111110. Between two flags, any 0 that follows five consecutive 1s is removed. The remaining bits are packed least significant bit first into bytes, and the bytes enter the buffer in arrival order, including the final two check bytes. `rd_valid` is high while the buffer holds a byte, and `rd_data` shows the oldest byte. A cycle with `rd_stb` high removes that byte.
- R3: A closing flag that ends a frame of at least two complete bytes sets `status[4]` and clears `status[3]`. The new value is visible one clock after the strobe that carries the flag's final 0. The value holds until the next such frame end.
- R4: Seven consecutive 1s inside a frame abort it. The abort sets `status[4]` and `status[3]`, clears `status[2]` and `status[0]`, and returns the receiver to flag search. Bits that arrive before the next flag are ignored.
- R5: At a flag-ended frame, `status[2]` is set when the number of frame bits after zero removal is not a multiple of 8, and is clear otherwise.
- R6: A byte written while the four-entry buffer is full, with no read in the same cycle, replaces the oldest byte and keeps the newer ones. `status[1]` at the next reported frame end is set exactly when such an overwrite occurred since the previous reported frame end.
- R7: The CRC-16 uses x^16+x^12+x^5+1 in bit-reversed form 0x8408. The register is preset to 0xFFFF and is fed least significant bit first over every frame bit, check bytes included. At a flag-ended frame, `status[0]` is set when `fcs_chk_en` is high and the final register value differs from 0xF0B8. It stays clear when `fcs_chk_en` is low.
- R8: Back-to-back flags, frames with fewer than two complete bytes, and abort runs received while searching for a flag leave `status` unchanged.
- R9: `status[7:5]` is always zero. `status` changes only on the clock after a cycle with `bit_en` high.
- R10: While `bit_en` and `rd_stb` are low, a nonempty buffer keeps `rd_valid` high and `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | High for one cycle per received line bit |
| rx_bit | input | 1 | Serial line bit, sampled when `bit_en` is high |
| fcs_chk_en | input | 1 | Enables the CRC-16 error report |
| rd_stb | input | 1 | Removes the oldest buffered byte |
| rd_data | output | 8 | Oldest buffered byte |
| rd_valid | output | 1 | Buffer holds at least one byte |
| status | output | 8 | Frame-end status: bit 4 ended, bit 3 abort, bit 2 not whole bytes, bit 1 overwrite, bit 0 CRC error |

## Verification
A wrong run-of-ones count shows at the ports within one byte time. Either a delivered byte carries a stray or missing bit, or a delimiter is missed and `status` fails to change on the clock after the flag's final bit. A corrupted CRC register or bit-position counter does not show up until the frame closes, where it sets `status[0]` or `status[2]` wrongly. A buffer pointer fault shows on the next read as a byte out of order or a wrong `rd_valid`. The bench sweeps every single-byte payload, every single-bit error in one frame and every frame length from 16 to 31 bits. Each case is checked at the exact clock where the change is expected.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int          CRC_W      = 16;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;
    localparam logic [15:0] CRC_GOOD   = 16'hF0B8;
    localparam int          RUN_W      = 3;
    localparam int          STUFF_RUN  = 5;
    localparam int          DELIM_RUN  = 6;
    localparam int          EOF_BITS   = 5;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_DATA,
        EV_STUFF,
        EV_FLAG,
        EV_ABORT
    } line_ev_e;

    typedef enum logic {
        ST_HUNT,
        ST_FRAME
    } rx_state_e;

    typedef struct packed {
        logic ended;
        logic aborted;
        logic odd_len;
        logic lost_byte;
        logic crc_bad;
    } eof_stat_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        return (c >> 1) ^ ((c[0] ^ b) ? CRC_POLY_R : '0);
    endfunction

endpackage

// File: rtl/hdlc_line_dec.sv
module hdlc_line_dec
    import hdlc_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_en,
    input  logic     rx_bit,
    output line_ev_e ev
);

    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0] run_q;

    always_comb begin
        ev = EV_NONE;
        if (bit_en) begin
            if (rx_bit) begin
                if (run_q == RUN_W'(DELIM_RUN))
                    ev = EV_ABORT;
                else if (run_q < RUN_W'(DELIM_RUN))
                    ev = EV_DATA;
            end else begin
                if (run_q == RUN_W'(DELIM_RUN))
                    ev = EV_FLAG;
                else if (run_q == RUN_W'(STUFF_RUN))
                    ev = EV_STUFF;
                else
                    ev = EV_DATA;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (bit_en)
            run_q <= rx_bit ? ((run_q == RUN_MAX) ? RUN_MAX : run_q + 1'b1) : '0;
    end

endmodule

// File: rtl/hdlc_bit_delay.sv
module hdlc_bit_delay #(
    parameter int DEPTH = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic push,
    input  logic din,
    output logic commit,
    output logic cbit
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] line_q;
    logic [CW-1:0]    fill_q;

    assign commit = push && (fill_q == CW'(DEPTH));
    assign cbit   = line_q[DEPTH-1];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            line_q <= '0;
            fill_q <= '0;
        end else if (push) begin
            line_q <= {line_q[DEPTH-2:0], din};
            if (fill_q != CW'(DEPTH))
                fill_q <= fill_q + 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_byte_fifo.sv
module hdlc_byte_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         valid,
    output logic         overwrite
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rp_q, wp_q;
    logic [CW-1:0] cnt_q;
    logic          full, do_rd, inc;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (cnt_q == CW'(DEPTH));
    assign valid     = (cnt_q != '0);
    assign do_rd     = rd && valid;
    assign overwrite = wr && full && !do_rd;
    assign inc       = wr && (!full || do_rd);
    assign rdata     = mem[rp_q];

    always_ff @(posedge clk) begin
        if (wr)
            mem[wp_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp_q  <= '0;
            wp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr)
                wp_q <= nxt(wp_q);
            if (do_rd || overwrite)
                rp_q <= nxt(rp_q);
            cnt_q <= cnt_q + CW'(inc) - CW'(do_rd);
        end
    end

endmodule

// File: rtl/hdlc_dl_rx.sv
module hdlc_dl_rx
    import hdlc_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int STAT_W     = 8,
    parameter int LOOKBEHIND = 7,
    parameter int MIN_BYTES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              fcs_chk_en,
    input  logic              rd_stb,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic [STAT_W-1:0] status
);

    localparam int NBW = $clog2(MIN_BYTES + 1);

    line_ev_e         ev;
    rx_state_e        state_q;
    logic             in_frame, dpush, flush, commit, cbit;
    logic [7:0]       asm_q, byte_w;
    logic [2:0]       bpos_q;
    logic             byte_done;
    logic [CRC_W-1:0] crc_q;
    logic [NBW-1:0]   nbytes_q;
    logic             ovf_seen_q, fifo_ovw;
    logic             frame_end, report, restart;
    eof_stat_t        stat_q;

    hdlc_line_dec u_line (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .rx_bit (rx_bit),
        .ev     (ev)
    );

    assign in_frame = (state_q == ST_FRAME);
    assign dpush    = in_frame && (ev == EV_DATA);
    assign flush    = (ev == EV_FLAG) || (ev == EV_ABORT);

    hdlc_bit_delay #(.DEPTH(LOOKBEHIND)) u_delay (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .push   (dpush),
        .din    (rx_bit),
        .commit (commit),
        .cbit   (cbit)
    );

    assign byte_w    = {cbit, asm_q[7:1]};
    assign byte_done = commit && (bpos_q == 3'd7);

    hdlc_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr        (byte_done),
        .wdata     (byte_w),
        .rd        (rd_stb),
        .rdata     (rd_data),
        .valid     (rd_valid),
        .overwrite (fifo_ovw)
    );

    assign frame_end = in_frame && flush;
    assign report    = frame_end && (nbytes_q >= NBW'(MIN_BYTES));
    assign restart   = flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
        end else if (ev == EV_FLAG) begin
            state_q <= ST_FRAME;
        end else if (ev == EV_ABORT) begin
            state_q <= ST_HUNT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            asm_q    <= '0;
            bpos_q   <= '0;
            crc_q    <= CRC_PRESET;
            nbytes_q <= '0;
        end else if (commit) begin
            asm_q  <= byte_w;
            bpos_q <= bpos_q + 1'b1;
            crc_q  <= crc_step(crc_q, cbit);
            if (byte_done && (nbytes_q != NBW'(MIN_BYTES)))
                nbytes_q <= nbytes_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovf_seen_q <= 1'b0;
        else if (report)
            ovf_seen_q <= 1'b0;
        else if (fifo_ovw)
            ovf_seen_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else if (report) begin
            stat_q.ended     <= 1'b1;
            stat_q.aborted   <= (ev == EV_ABORT);
            stat_q.odd_len   <= (ev == EV_FLAG) && (bpos_q != 3'd0);
            stat_q.lost_byte <= ovf_seen_q;
            stat_q.crc_bad   <= (ev == EV_FLAG) && fcs_chk_en && (crc_q != CRC_GOOD);
        end
    end

    assign status = STAT_W'(stat_q);

endmodule

// File: rtl/hdlc_dl_rx_chk.sv
module hdlc_dl_rx_chk #(
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_en,
    input logic              fcs_chk_en,
    input logic              rd_stb,
    input logic [7:0]        rd_data,
    input logic              rd_valid,
    input logic [STAT_W-1:0] status
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (status == '0 && !rd_valid));

    a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (status >> 5) == '0);

    a_r9_quiet_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(status));

    a_r4_abort_ended: assert property (@(posedge clk) disable iff (rst)
        status[3] |-> status[4]);

    a_r4_abort_no_len_crc: assert property (@(posedge clk) disable iff (rst)
        status[3] |-> (!status[2] && !status[0]));

    a_r7_no_err_disabled: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !fcs_chk_en) |=> (!status[0] || $stable(status)));

    a_r10_head_held: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_stb && !bit_en) |=> (rd_valid && $stable(rd_data)));

endmodule

bind hdlc_dl_rx hdlc_dl_rx_chk #(.STAT_W(STAT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .fcs_chk_en (fcs_chk_en),
    .rd_stb     (rd_stb),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .status     (status)
);

// File: tb/hdlc_dl_rx_tb.sv
module hdlc_dl_rx_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b0;
    logic       fcs_chk_en = 1'b1;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [7:0] status;

    int n_chk  = 0;
    int n_fail = 0;
    int tx_ones = 0;
    logic fb [0:127];
    int   fn = 0;

    always #4 clk = ~clk;

    hdlc_dl_rx u_dut (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .rx_bit     (rx_bit),
        .fcs_chk_en (fcs_chk_en),
        .rd_stb     (rd_stb),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .status     (status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tx_raw(input logic b);
        rx_bit = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic tx_flag();
        tx_raw(1'b0);
        for (int i = 0; i < 6; i++) tx_raw(1'b1);
        tx_raw(1'b0);
        tx_ones = 0;
    endtask

    task automatic tx_stuffed(input logic b);
        tx_raw(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                tx_raw(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    function automatic logic [15:0] bench_crc(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++)
            c = (c[0] ^ fb[i]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        return c;
    endfunction

    task automatic fb_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            fb[fn] = v[i];
            fn++;
        end
    endtask

    task automatic fb_fcs();
        logic [15:0] f;
        f = ~bench_crc(fn);
        for (int i = 0; i < 16; i++) begin
            fb[fn] = f[i];
            fn++;
        end
    endtask

    function automatic logic [7:0] fb_get(input int k);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = fb[8*k + i];
        return v;
    endfunction

    task automatic send_frame();
        tx_flag();
        for (int i = 0; i < fn; i++) tx_stuffed(fb[i]);
        tx_flag();
    endtask

    task automatic drain(input string req, input int first, input int count);
        for (int k = first; k < first + count; k++) begin
            chk({req, " valid"}, 32'(rd_valid), 32'd1);
            chk({req, " byte"}, 32'(rd_data), 32'(fb_get(k)));
            rd_stb = 1'b1;
            @(negedge clk);
            rd_stb = 1'b0;
        end
        chk({req, " empty"}, 32'(rd_valid), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] held_s, held_d;
        logic       err;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 status", 32'(status), 32'h00);
        chk("R1 valid", 32'(rd_valid), 32'd0);

        // R8: abort-length runs of ones while searching for a flag
        for (int i = 0; i < 15; i++) tx_raw(1'b1);
        chk("R8 hunt abort", 32'(status), 32'h00);
        chk("R8 hunt empty", 32'(rd_valid), 32'd0);

        // R2 R3 R7: every single-byte payload with a correct check sequence
        for (int v = 0; v < 256; v++) begin
            fn = 0;
            fb_byte(8'(v));
            fb_fcs();
            send_frame();
            chk("R3 good frame", 32'(status), 32'h10);
            drain("R2", 0, 3);
        end

        // R2: payloads dense in ones, forcing zero removal
        for (int j = 0; j < 4; j++) begin
            logic [7:0] pat [4] = '{8'hFF, 8'h7E, 8'hFC, 8'h3F};
            fn = 0;
            fb_byte(pat[j]);
            fb_byte(8'hFF);
            fb_fcs();
            send_frame();
            chk("R3 stuffed frame", 32'(status), 32'h10);
            drain("R2 stuffed", 0, 4);
        end

        // R10: head byte and status held while idle
        fn = 0;
        fb_byte(8'hA5);
        fb_fcs();
        send_frame();
        held_s = status;
        held_d = rd_data;
        repeat (6) @(negedge clk);
        chk("R10 data held", 32'(rd_data), 32'(held_d));
        chk("R9 status held", 32'(status), 32'(held_s));
        drain("R10", 0, 3);

        // R7: every single-bit error is reported when checking is enabled
        for (int j = 0; j < 24; j++) begin
            fn = 0;
            fb_byte(8'hA5);
            fb_fcs();
            fb[j] = ~fb[j];
            fcs_chk_en = 1'b1;
            send_frame();
            chk("R7 crc error", 32'(status), 32'h11);
            drain("R7", 0, 3);
        end
        // R7: same corruption with checking disabled
        for (int j = 0; j < 24; j += 5) begin
            fn = 0;
            fb_byte(8'h3C);
            fb_fcs();
            fb[j] = ~fb[j];
            fcs_chk_en = 1'b0;
            send_frame();
            chk("R7 disabled", 32'(status), 32'h10);
            drain("R7 dis", 0, 3);
        end
        fcs_chk_en = 1'b1;

        // R5: lengths 16..31 bits
        for (int n = 16; n < 32; n++) begin
            fn = n;
            for (int i = 0; i < n; i++) fb[i] = ((i * 5 + n) % 3) != 0;
            err = (bench_crc(n) != 16'hF0B8);
            send_frame();
            chk("R5 length status", 32'(status),
                32'({1'b1, 1'b0, (n % 8) != 0, 1'b0, err}));
            drain("R5", 0, n / 8);
        end

        // R8: back-to-back flags and short fragments
        fn = 0;
        fb_byte(8'h5A);
        fb_fcs();
        fb[3] = ~fb[3];
        send_frame();
        chk("R8 setup", 32'(status), 32'h11);
        drain("R8 setup", 0, 3);
        tx_flag();
        tx_flag();
        chk("R8 flags", 32'(status), 32'h11);
        fn = 7;
        for (int i = 0; i < 7; i++) fb[i] = i[0];
        send_frame();
        chk("R8 7-bit", 32'(status), 32'h11);
        chk("R8 7-bit empty", 32'(rd_valid), 32'd0);
        fn = 12;
        for (int i = 0; i < 12; i++) fb[i] = (i % 3) == 0;
        send_frame();
        chk("R8 12-bit", 32'(status), 32'h11);
        drain("R8 12-bit", 0, 1);

        // R6: five bytes into a four-entry buffer without reads
        fn = 0;
        fb_byte(8'h11);
        fb_byte(8'h22);
        fb_byte(8'h33);
        fb_fcs();
        send_frame();
        chk("R6 overwrite", 32'(status), 32'h12);
        drain("R6 newest kept", 1, 4);
        fn = 0;
        fb_byte(8'h44);
        fb_fcs();
        send_frame();
        chk("R6 cleared", 32'(status), 32'h10);
        drain("R6 next", 0, 3);

        // R4: abort after three bytes, then ignored bits until a flag
        fn = 0;
        fb_byte(8'h12);
        fb_byte(8'h34);
        fb_byte(8'h56);
        tx_flag();
        for (int i = 0; i < fn; i++) tx_stuffed(fb[i]);
        for (int i = 0; i < 8; i++) tx_raw(1'b1);
        chk("R4 abort", 32'(status), 32'h18);
        drain("R4", 0, 2);
        for (int i = 0; i < 20; i++) tx_raw(i[0] ^ i[2]);
        chk("R4 hunt status", 32'(status), 32'h18);
        chk("R4 hunt empty", 32'(rd_valid), 32'd0);
        fn = 0;
        fb_byte(8'h9C);
        fb_fcs();
        send_frame();
        chk("R4 resync", 32'(status), 32'h10);
        drain("R4 resync", 0, 3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule